// File: doc/BRIEF.md
# Hit list write controller

This block files a stream of detector hits into a small database keyed by the superstrip ID (SSID) that arrives with each hit. On each clock, one hit word and its SSID come in, marked by a valid flag. The last hit of an event also carries an end-of-event flag. The hit is appended to a sequential hit-list memory. The list address of the first hit of every run of equal SSIDs goes into a pointer memory indexed by the full SSID. A running count of the run's length goes into one of several count banks. The low don't-care bits of the SSID pick the bank, and the upper SSID bits address it.

A matching read-out stage later uses the three memories to pull back every hit whose SSID falls inside a pattern, with the low bits treated as don't-care. Between events the count banks are never bulk-cleared. Instead, a bitmap with one bit per upper-SSID value records which bank rows the current event has already cleared. The first hit of an event to land on a row clears all banks in that row at once. The default parameters give a reduced build: a 10-bit SSID with 3 don't-care bits, 1024 list entries of 32 bits and 5-bit counts. The full-size build uses a 14-bit SSID. Three asynchronous inspection ports read back the memories.

Top module: `hitlist_writer`

## Requirements
- R1: After reset, wr_ovflw is 0 and event_closed is 1, so the first valid hit opens a new event.
- R2: The hits an event accepts are written to the hit-list memory in arrival order at addresses 0, 1, 2, and so on. The address restarts at 0 for every event.
- R3: For each run of back-to-back hits with the same full SSID, the pointer memory entry at that SSID holds the list address of the run's first hit.
- R4: The count read for an SSID equals the number of accepted hits in its latest run. The count is read at bank SSID[2:0] (the don't-care field), row SSID[SSID_W-1:3].
- R5: When a row is first touched in an event, the counts of all eight banks in that row read 0, except the bank of the hit's own SSID.
- R6: Returning to a row already touched in the same event writes a count of 1 to the selected bank. The other banks of that row keep their values.
- R7: When the full SSID changes but the upper SSID stays the same, a new run begins with count 1 and a new pointer entry. The other banks are not cleared.
- R8: event_closed goes to 1 on the cycle after a valid hit with in_eoe=1 and falls with the next valid hit. That hit starts a new event: the row bitmap is empty again and the list address is back at 0.
- R9: A hit that would push a run's count past 2^CNT_W-1 (31) is dropped and wr_ovflw is set. Every later hit of that event is dropped.
- R10: A hit that arrives once all 2^LIST_AW list entries of the event are used is dropped and wr_ovflw is set.
- R11: wr_ovflw stays at 1 until the first hit of the next event, which clears it.
- R12: A cycle with in_valid=0 writes nothing, whatever values in_ssid, in_hit and in_eoe carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Hit present this cycle |
| in_ssid | input | SSID_W | Superstrip ID of the hit |
| in_hit | input | HIT_W | Hit word |
| in_eoe | input | 1 | Last hit of the event |
| event_closed | output | 1 | The previous event has ended and the next hit opens a new one |
| wr_ovflw | output | 1 | Sticky write overflow for the current event |
| rd_ssid | input | SSID_W | Inspection SSID for count and pointer |
| rd_count | output | CNT_W | Count stored for rd_ssid |
| rd_ptr | output | LIST_AW | Pointer stored for rd_ssid |
| rd_hit_addr | input | LIST_AW | Inspection hit-list address |
| rd_hit | output | HIT_W | Hit stored at rd_hit_addr |

## Verification
The assertions assume that reset is applied before the first hit, and that in_ssid, in_hit and in_eoe only matter while in_valid is high. They also assume that an event's hits of one SSID come back to back, because a gap is treated as a fresh run. The stimulus keeps runs contiguous and always ends an event with an end-of-event hit. During idle cycles it drives random garbage on the data and end-of-event inputs, which tests that these cycles are ignored. Rows are drawn from a narrow range so that the same row is revisited within an event and across events. The overflow cases are reached by directed runs longer than the count width allows and by events longer than the list.

// File: rtl/hlw_pkg.sv
package hlw_pkg;
   // Verdict for one incoming hit
   typedef enum logic [1:0] {
      HLW_KEEP        = 2'd0,
      HLW_DROP_STICKY = 2'd1,
      HLW_DROP_FULL   = 2'd2,
      HLW_DROP_SAT    = 2'd3
   } hlw_verdict_e;
endpackage

// File: rtl/hlw_ram.sv
module hlw_ram #(
   parameter int W  = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/hlw_count_banks.sv
module hlw_count_banks #(
   parameter int UP_W  = 7,
   parameter int DC_W  = 3,
   parameter int CNT_W = 5
) (
   input  logic                clk,
   input  logic [(1<<DC_W)-1:0] bank_we,
   input  logic [UP_W-1:0]     wr_upper,
   input  logic [DC_W-1:0]     wr_sel,
   input  logic [CNT_W-1:0]    wr_value,
   input  logic [UP_W-1:0]     rd_upper,
   input  logic [DC_W-1:0]     rd_sel,
   output logic [CNT_W-1:0]    rd_value
);
   localparam int NBANK = 1 << DC_W;

   logic [CNT_W-1:0] bank_q [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [CNT_W-1:0] wd;
      // the selected bank takes the count, the rest of a cleared row take zero
      assign wd = (wr_sel == DC_W'(b)) ? wr_value : '0;
      hlw_ram #(.W(CNT_W), .AW(UP_W)) u_ram (
         .clk   (clk),
         .we    (bank_we[b]),
         .waddr (wr_upper),
         .wdata (wd),
         .raddr (rd_upper),
         .rdata (bank_q[b])
      );
   end

   assign rd_value = bank_q[rd_sel];
endmodule

// File: rtl/hlw_ctrl.sv
module hlw_ctrl
   import hlw_pkg::*;
#(
   parameter int SSID_W  = 10,
   parameter int DC_W    = 3,
   parameter int LIST_AW = 10,
   parameter int CNT_W   = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [SSID_W-1:0]       in_ssid,
   input  logic                    in_eoe,
   output logic                    hl_we,
   output logic [LIST_AW-1:0]      hl_addr,
   output logic                    ptr_we,
   output logic [SSID_W-DC_W-1:0]  cnt_upper,
   output logic [DC_W-1:0]         cnt_sel,
   output logic [CNT_W-1:0]        cnt_value,
   output logic [(1<<DC_W)-1:0]    bank_we,
   output logic                    event_closed,
   output logic                    wr_ovflw
);
   localparam int UP_W  = SSID_W - DC_W;
   localparam int NBANK = 1 << DC_W;
   localparam int ROWS  = 1 << UP_W;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic                fresh_q, ovf_q;
   logic [LIST_AW:0]    addr_q;
   logic [CNT_W-1:0]    run_q;
   logic [SSID_W-1:0]   prev_q;
   logic [ROWS-1:0]     rowmap_q;

   logic [LIST_AW:0]    cur_addr;
   logic                ovf_now, new_run, row_seen, clear_row, accept;
   logic [ROWS-1:0]     rowmap_base, rowmap_next;
   hlw_verdict_e        verdict;

   assign cnt_upper = in_ssid[SSID_W-1:DC_W];
   assign cnt_sel   = in_ssid[DC_W-1:0];

   // a fresh event sees an empty bitmap, list address 0 and no overflow
   assign cur_addr    = fresh_q ? '0 : addr_q;
   assign ovf_now     = fresh_q ? 1'b0 : ovf_q;
   assign new_run     = fresh_q || (in_ssid != prev_q);
   assign rowmap_base = fresh_q ? '0 : rowmap_q;
   assign row_seen    = rowmap_base[cnt_upper];
   assign cnt_value   = new_run ? CNT_W'(1) : run_q + CNT_W'(1);

   always_comb begin
      if (ovf_now)                          verdict = HLW_DROP_STICKY;
      else if (cur_addr[LIST_AW])           verdict = HLW_DROP_FULL;
      else if (!new_run && run_q == CNT_MAX) verdict = HLW_DROP_SAT;
      else                                  verdict = HLW_KEEP;
   end

   always_comb begin
      rowmap_next            = rowmap_base;
      rowmap_next[cnt_upper] = 1'b1;
   end

   assign accept    = in_valid && (verdict == HLW_KEEP);
   assign clear_row = accept && !row_seen;
   assign hl_we     = accept;
   assign hl_addr   = cur_addr[LIST_AW-1:0];
   assign ptr_we    = accept && new_run;

   for (genvar b = 0; b < NBANK; b++) begin : g_we
      assign bank_we[b] = clear_row || (accept && cnt_sel == DC_W'(b));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh_q  <= 1'b1;
         ovf_q    <= 1'b0;
         addr_q   <= '0;
         run_q    <= '0;
         prev_q   <= '0;
         rowmap_q <= '0;
      end else if (in_valid) begin
         fresh_q <= in_eoe;
         ovf_q   <= ovf_now || (verdict != HLW_KEEP);
         if (verdict == HLW_KEEP) begin
            addr_q   <= cur_addr + (LIST_AW+1)'(1);
            run_q    <= cnt_value;
            prev_q   <= in_ssid;
            rowmap_q <= rowmap_next;
         end
      end
   end

   assign event_closed = fresh_q;
   assign wr_ovflw     = ovf_q;
endmodule

// File: rtl/hitlist_writer.sv
module hitlist_writer #(
   parameter int SSID_W  = 10,
   parameter int DC_W    = 3,
   parameter int HIT_W   = 32,
   parameter int LIST_AW = 10,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [SSID_W-1:0]  in_ssid,
   input  logic [HIT_W-1:0]   in_hit,
   input  logic               in_eoe,
   output logic               event_closed,
   output logic               wr_ovflw,
   input  logic [SSID_W-1:0]  rd_ssid,
   output logic [CNT_W-1:0]   rd_count,
   output logic [LIST_AW-1:0] rd_ptr,
   input  logic [LIST_AW-1:0] rd_hit_addr,
   output logic [HIT_W-1:0]   rd_hit
);
   localparam int UP_W  = SSID_W - DC_W;
   localparam int NBANK = 1 << DC_W;

   // elaboration-time parameter checks
   if (DC_W < 1 || DC_W > 4) begin : g_bad_dc
      $error("hitlist_writer: DC_W must lie in 1..4");
   end
   if (SSID_W <= DC_W) begin : g_bad_ssid
      $error("hitlist_writer: SSID_W must exceed DC_W");
   end
   if (CNT_W < 2 || HIT_W < 1 || LIST_AW < 1) begin : g_bad_width
      $error("hitlist_writer: CNT_W >= 2, HIT_W >= 1, LIST_AW >= 1 required");
   end

   logic                hl_we, ptr_we;
   logic [LIST_AW-1:0]  hl_addr;
   logic [UP_W-1:0]     cnt_upper;
   logic [DC_W-1:0]     cnt_sel;
   logic [CNT_W-1:0]    cnt_value;
   logic [NBANK-1:0]    bank_we;

   hlw_ctrl #(
      .SSID_W(SSID_W), .DC_W(DC_W), .LIST_AW(LIST_AW), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ssid      (in_ssid),
      .in_eoe       (in_eoe),
      .hl_we        (hl_we),
      .hl_addr      (hl_addr),
      .ptr_we       (ptr_we),
      .cnt_upper    (cnt_upper),
      .cnt_sel      (cnt_sel),
      .cnt_value    (cnt_value),
      .bank_we      (bank_we),
      .event_closed (event_closed),
      .wr_ovflw     (wr_ovflw)
   );

   hlw_count_banks #(.UP_W(UP_W), .DC_W(DC_W), .CNT_W(CNT_W)) u_banks (
      .clk      (clk),
      .bank_we  (bank_we),
      .wr_upper (cnt_upper),
      .wr_sel   (cnt_sel),
      .wr_value (cnt_value),
      .rd_upper (rd_ssid[SSID_W-1:DC_W]),
      .rd_sel   (rd_ssid[DC_W-1:0]),
      .rd_value (rd_count)
   );

   hlw_ram #(.W(LIST_AW), .AW(SSID_W)) u_ptr (
      .clk   (clk),
      .we    (ptr_we),
      .waddr (in_ssid),
      .wdata (hl_addr),
      .raddr (rd_ssid),
      .rdata (rd_ptr)
   );

   hlw_ram #(.W(HIT_W), .AW(LIST_AW)) u_list (
      .clk   (clk),
      .we    (hl_we),
      .waddr (hl_addr),
      .wdata (in_hit),
      .raddr (rd_hit_addr),
      .rdata (rd_hit)
   );
endmodule

// File: rtl/hlw_checker.sv
module hlw_checker #(
   parameter int NB = 8,
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_eoe,
   input logic          event_closed,
   input logic          wr_ovflw,
   input logic          hl_we,
   input logic          ptr_we,
   input logic [NB-1:0] bank_we,
   input logic [AW-1:0] hl_addr
);
   assert_list_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hl_we && !in_eoe) |=> (!hl_we || hl_addr == $past(hl_addr) + AW'(1)));

   assert_ptr_with_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |-> hl_we);

   assert_bank_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we) || ($countones(bank_we) == NB));

   assert_close_after_eoe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eoe) |=> event_closed);

   assert_sticky_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ovflw && !(in_valid && event_closed)) |=> wr_ovflw);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ovflw && !event_closed) |-> (!hl_we && !ptr_we && bank_we == '0));

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!hl_we && !ptr_we && bank_we == '0));
endmodule

bind hitlist_writer hlw_checker #(.NB(NBANK), .AW(LIST_AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_eoe       (in_eoe),
   .event_closed (event_closed),
   .wr_ovflw     (wr_ovflw),
   .hl_we        (hl_we),
   .ptr_we       (ptr_we),
   .bank_we      (bank_we),
   .hl_addr      (hl_addr)
);

// File: tb/hitlist_writer_test.sv
module hitlist_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int SSID_W  = 10;
   localparam int DC_W    = 3;
   localparam int HIT_W   = 32;
   localparam int LIST_AW = 10;
   localparam int CNT_W   = 5;
   localparam int NSSID   = 1 << SSID_W;
   localparam int NROW    = 1 << (SSID_W - DC_W);
   localparam int NLIST   = 1 << LIST_AW;
   localparam int CMAX    = (1 << CNT_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_eoe = 1'b0;
   logic [SSID_W-1:0]  in_ssid = '0, rd_ssid = '0;
   logic [HIT_W-1:0]   in_hit = '0, rd_hit;
   logic [LIST_AW-1:0] rd_hit_addr = '0, rd_ptr;
   logic [CNT_W-1:0]   rd_count;
   logic event_closed, wr_ovflw;

   int checks = 0, failures = 0;
   bit done = 0;

   // bench model state
   bit   m_fresh = 1, m_ovf = 0, m_have = 0;
   int   m_addr = 0, m_run = 0, m_prev = 0;
   bit   m_row [NROW];
   bit   m_pset [NSSID];
   int   m_cnt [NSSID];
   int   m_ptr [NSSID];
   logic [HIT_W-1:0] m_hit [NLIST];

   always #(CLK_PERIOD/2) clk = ~clk;

   hitlist_writer #(.SSID_W(SSID_W), .DC_W(DC_W), .HIT_W(HIT_W),
                    .LIST_AW(LIST_AW), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ssid(in_ssid),
      .in_hit(in_hit), .in_eoe(in_eoe), .event_closed(event_closed),
      .wr_ovflw(wr_ovflw), .rd_ssid(rd_ssid), .rd_count(rd_count),
      .rd_ptr(rd_ptr), .rd_hit_addr(rd_hit_addr), .rd_hit(rd_hit));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected effect of one hit, from the requirements
   task automatic model(input int s, input logic [HIT_W-1:0] h, input bit eoe);
      bit newrun;
      if (m_fresh) begin
         foreach (m_row[i])  m_row[i] = 0;
         foreach (m_pset[i]) m_pset[i] = 0;
         m_addr = 0; m_ovf = 0; m_have = 0;
      end
      newrun = !m_have || (s != m_prev);
      if (m_ovf) begin
      end else if (m_addr == NLIST) m_ovf = 1;
      else if (!newrun && m_run == CMAX) m_ovf = 1;
      else begin
         m_hit[m_addr] = h;
         if (newrun) begin m_ptr[s] = m_addr; m_pset[s] = 1; m_run = 1; end
         else m_run++;
         if (!m_row[s >> DC_W]) begin
            m_row[s >> DC_W] = 1;
            for (int k = 0; k < (1 << DC_W); k++) m_cnt[((s >> DC_W) << DC_W) + k] = 0;
         end
         m_cnt[s] = m_run;
         m_addr++; m_prev = s; m_have = 1;
      end
      m_fresh = eoe;
   endtask

   task automatic send(input int s, input logic [HIT_W-1:0] h, input bit eoe);
      model(s, h, eoe);
      @(negedge clk);
      in_valid = 1'b1; in_ssid = SSID_W'(s); in_hit = h; in_eoe = eoe;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_ssid = SSID_W'($urandom); in_hit = $urandom; in_eoe = 1'($urandom);
      end
   endtask

   task automatic compare(input string tag);
      for (int s = 0; s < NSSID; s++) begin
         if (m_row[s >> DC_W]) begin
            rd_ssid = SSID_W'(s); #1;
            chk(rd_count == CNT_W'(m_cnt[s]), {tag, " count R4 R5 R6"}, rd_count, m_cnt[s]);
            if (m_pset[s])
               chk(rd_ptr == LIST_AW'(m_ptr[s]), {tag, " pointer R3 R7"}, rd_ptr, m_ptr[s]);
         end
      end
      for (int a = 0; a < m_addr; a++) begin
         rd_hit_addr = LIST_AW'(a); #1;
         chk(rd_hit == m_hit[a], {tag, " hit list R2"}, rd_hit, m_hit[a]);
      end
   endtask

   function automatic int mk(input int up, input int lo);
      return (up << DC_W) | lo;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_ovflw == 1'b0, "R1 ovflw after reset", wr_ovflw, 0);
      chk(event_closed == 1'b1, "R1 closed after reset", event_closed, 1);

      // directed: runs, same-row switch, revisit of a row
      send(mk(5,2), 32'hA001, 0); send(mk(5,2), 32'hA002, 0); send(mk(5,2), 32'hA003, 0);
      send(mk(5,4), 32'hA004, 0);                                   // R7
      send(mk(9,0), 32'hA005, 0); send(mk(9,0), 32'hA006, 0);
      send(mk(5,6), 32'hA007, 1);                                   // R6
      idle(4);                                                      // R12 garbage
      chk(event_closed == 1'b1, "R8 closed after eoe", event_closed, 1);
      compare("directed A");

      // next event: row 5 cleared lazily on first touch
      send(mk(5,1), 32'hB001, 0);
      idle(1);
      chk(event_closed == 1'b0, "R8 open after first hit", event_closed, 0);
      send(mk(5,1), 32'hB002, 1);
      idle(2);
      compare("directed B R5 R8");

      // count saturation
      send(mk(3,3), 32'hC000, 0);
      for (int i = 0; i < CMAX + 2; i++) send(mk(7,5), 32'hC100 + i, 0);
      send(mk(3,3), 32'hC999, 1);
      idle(2);
      chk(wr_ovflw == 1'b1, "R9 ovflw on count", wr_ovflw, 1);
      compare("count overflow R9");

      send(mk(1,1), 32'hD001, 1);
      idle(2);
      chk(wr_ovflw == 1'b0, "R11 ovflw cleared", wr_ovflw, 0);
      compare("after overflow R11");

      // list overflow
      for (int i = 0; i < NLIST + 2; i++) send(i % NSSID, $urandom, i == NLIST + 1);
      idle(2);
      chk(wr_ovflw == 1'b1, "R10 ovflw on list", wr_ovflw, 1);
      compare("list overflow R10");

      // random events
      for (int e = 0; e < 20; e++) begin
         int n = 5 + int'($urandom_range(55));
         int sent = 0;
         while (sent < n) begin
            int s = mk(int'($urandom_range(15)), int'($urandom_range(7)));
            int len = 1 + int'($urandom_range(3));
            for (int j = 0; j < len && sent < n; j++) begin
               sent++;
               send(s, $urandom, sent == n);
            end
            if ($urandom_range(3) == 0) idle(1);
         end
         idle(2);
         chk(event_closed == 1'b1, "R8 closed after random event", event_closed, 1);
         chk(wr_ovflw == 1'(m_ovf), "R11 random ovflw", wr_ovflw, m_ovf);
         compare("random R2 R4");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule